// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block decides when probe samples are written into a sample memory of fixed depth. It drives the write address and write enable of the probe-side port of a dual-port memory, and it is the only source of those two signals. A host programs a capture mode and a pre-trigger count into configuration registers, then pulses a start input. The controller fills the memory according to the mode and the trigger input. When it finishes, it reports a DONE state and the address of the oldest stored sample. The host reads the memory from that address upward, wrapping at the depth, and so gets the samples in time order.

There are three modes. In single-shot mode, once the trigger fires, a sample is written on every cycle. In incremental mode, after the trigger, a sample is written only on cycles where the trigger is high. In immediate mode the trigger is not used and writing starts at once. Before the trigger, the controller keeps a programmable number of earlier samples by treating the memory as a circular buffer.

Top module: `la_capture_ctrl`

## Requirements
- R1: After reset the state is IDLE (code 0), the write enable is low, the write address and the start address are 0, and the configuration holds single-shot mode with a pre-trigger count of DEPTH/2.
- R2: State codes are IDLE=0, FILLING=1, ARMED=2, CAPTURING=3 and DONE=4. A start pulse is accepted only in IDLE or DONE, and it captures the configuration at that moment. A start pulse in any other state is ignored, and configuration writes made during a capture do not affect that capture.
- R3: FILLING writes one sample on every cycle, starting at address 0, until P pre-trigger samples have been stored, and then enters ARMED. A trigger seen during FILLING is ignored.
- R4: In ARMED with P>0, a sample is written on every cycle and the address wraps modulo DEPTH. In ARMED with P=0, nothing is written until the trigger arrives.
- R5: P = min(position, DEPTH-1). A position of 0 puts the trigger sample first in the capture. A position of DEPTH or more puts it last.
- R6: Single-shot mode (mode code 0) writes the trigger-cycle sample and then one sample on every cycle until DEPTH samples in time order have been kept, then enters DONE.
- R7: Incremental mode (mode code 1) writes the trigger-cycle sample and afterwards writes only on cycles where the trigger is high, until the capture is complete.
- R8: Immediate mode (mode code 2) ignores the trigger. It writes addresses 0 to DEPTH-1 on the DEPTH cycles that follow the start cycle, then enters DONE with a start address of 0.
- R9: In DONE, the start address is the address of the oldest kept sample. Reading DEPTH addresses upward from it, modulo DEPTH, returns the samples in time order.
- R10: No write occurs in IDLE or DONE. The write address stays below DEPTH, advances by one modulo DEPTH after each write, and holds on cycles without a write.
- R11: Mode code 3 behaves exactly as single-shot mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_mode_i | input | 2 | Capture mode code written with the strobe |
| cfg_pos_i | input | $clog2(DEPTH+1) | Pre-trigger sample count written with the strobe |
| start_i | input | 1 | One-cycle pulse that launches a capture |
| trig_i | input | 1 | Trigger condition from the comparators |
| wr_en_o | output | 1 | Sample memory write enable |
| wr_addr_o | output | $clog2(DEPTH) | Sample memory write address |
| state_o | output | 3 | Controller state code |
| start_addr_o | output | $clog2(DEPTH) | Address of the oldest kept sample |

## Verification
The assertions check several rules on every cycle. No write happens while idle or finished. The address stays in range, steps by one after each write and holds otherwise. FILLING never jumps straight to capture. In incremental capture the write enable follows the trigger, and in the other capture modes it stays high. A finished capture stays finished until the next start. Other behaviours can only be shown by the bench scenarios, which rebuild a model of the memory from observed writes and read it back from the reported start address. These behaviours are where the trigger lands inside the kept window at positions 0, mid and clamped, that early triggers are dropped, the exact samples an incremental run keeps, and that a configuration write or a start pulse in mid-capture leaves the capture unchanged.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FILL   = 3'd1,
        ST_ARMED  = 3'd2,
        ST_CAPT   = 3'd3,
        ST_DONE   = 3'd4
    } cap_state_e;

    typedef enum logic [1:0] {
        MD_SINGLE = 2'd0,
        MD_INCR   = 2'd1,
        MD_IMMED  = 2'd2,
        MD_ALT    = 2'd3
    } cap_mode_e;

endpackage

// File: rtl/la_cap_cfg.sv
// Host-written configuration: capture mode and pre-trigger count.
module la_cap_cfg
    import la_cap_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [1:0]    mode_i,
    input  logic [PW-1:0] pos_i,
    output cap_mode_e     mode_o,
    output logic [AW-1:0] pos_o
);

    typedef struct packed {
        cap_mode_e     mode;
        logic [AW-1:0] pos;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            // code 3 is folded onto single-shot
            cfg_d.mode = (mode_i == 2'd3) ? MD_SINGLE : cap_mode_e'(mode_i);
            // positions at or beyond the depth put the trigger on the last slot
            cfg_d.pos  = (pos_i >= PW'(DEPTH)) ? AW'(DEPTH - 1) : pos_i[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode <= MD_SINGLE;
            cfg_q.pos  <= AW'(DEPTH / 2);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o = cfg_q.mode;
    assign pos_o  = cfg_q.pos;

endmodule

// File: rtl/la_cap_oldest.sv
// Modulo-DEPTH subtraction: address lying BACK slots behind PTR.
module la_cap_oldest #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] back_i,
    output logic [AW-1:0] addr_o
);

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign addr_o = ptr_i - back_i;
        end else begin : g_npow2
            always_comb begin
                if (ptr_i >= back_i) addr_o = ptr_i - back_i;
                else                 addr_o = ptr_i + AW'(DEPTH) - back_i;
            end
        end
    endgenerate

endmodule

// File: rtl/la_cap_fsm.sv
// Capture sequencer: state, write pointer and remaining-sample counter.
module la_cap_fsm
    import la_cap_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          trig_i,
    input  cap_mode_e     cfg_mode_i,
    input  logic [AW-1:0] cfg_pos_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output cap_state_e    state_o,
    output cap_mode_e     act_mode_o,
    output logic [AW-1:0] oldest_o
);

    typedef struct packed {
        cap_state_e    st;
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;     // FILLING: stored so far; CAPTURING: writes left
        cap_mode_e     md;
        logic [AW-1:0] pos;
        logic [AW-1:0] oldest;
    } fsm_t;

    fsm_t q, d;
    logic          we;
    logic [AW-1:0] ptr_nx;
    logic [AW-1:0] oldest_at_ptr;
    logic [CW-1:0] post_left;

    la_cap_oldest #(.DEPTH(DEPTH)) u_oldest (
        .ptr_i  (q.ptr),
        .back_i (q.pos),
        .addr_o (oldest_at_ptr)
    );

    assign ptr_nx    = (q.ptr == AW'(DEPTH - 1)) ? '0 : q.ptr + 1'b1;
    assign post_left = CW'(DEPTH - 1) - CW'(q.pos);

    always_comb begin
        d  = q;
        we = 1'b0;
        unique case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    d.ptr = '0;
                    d.cnt = '0;
                    d.md  = cfg_mode_i;
                    d.pos = cfg_pos_i;
                    if (cfg_mode_i == MD_IMMED) begin
                        d.st     = ST_CAPT;
                        d.cnt    = CW'(DEPTH);
                        d.oldest = '0;
                    end else if (cfg_pos_i == '0) begin
                        d.st = ST_ARMED;
                    end else begin
                        d.st = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                we    = 1'b1;
                d.ptr = ptr_nx;
                d.cnt = q.cnt + CW'(1);
                if (q.cnt + CW'(1) == CW'(q.pos)) d.st = ST_ARMED;
            end
            ST_ARMED: begin
                we = (q.pos != '0) || trig_i;
                if (we) d.ptr = ptr_nx;
                if (trig_i) begin
                    d.oldest = oldest_at_ptr;
                    d.cnt    = post_left;
                    d.st     = (post_left == '0) ? ST_DONE : ST_CAPT;
                end
            end
            ST_CAPT: begin
                we = (q.md == MD_INCR) ? trig_i : 1'b1;
                if (we) begin
                    d.ptr = ptr_nx;
                    d.cnt = q.cnt - CW'(1);
                    if (q.cnt == CW'(1)) d.st = ST_DONE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.ptr    <= '0;
            q.cnt    <= '0;
            q.md     <= MD_SINGLE;
            q.pos    <= '0;
            q.oldest <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en_o    = we;
    assign wr_addr_o  = q.ptr;
    assign state_o    = q.st;
    assign act_mode_o = q.md;
    assign oldest_o   = q.oldest;

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
    import la_cap_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_mode_i,
    input  logic [PW-1:0] cfg_pos_i,
    input  logic          start_i,
    input  logic          trig_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [2:0]    state_o,
    output logic [AW-1:0] start_addr_o
);

    cap_mode_e     cfg_mode;
    logic [AW-1:0] cfg_pos;
    cap_mode_e     act_mode;
    cap_state_e    st;

    la_cap_cfg #(.DEPTH(DEPTH)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .mode_i (cfg_mode_i),
        .pos_i  (cfg_pos_i),
        .mode_o (cfg_mode),
        .pos_o  (cfg_pos)
    );

    la_cap_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .trig_i     (trig_i),
        .cfg_mode_i (cfg_mode),
        .cfg_pos_i  (cfg_pos),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .state_o    (st),
        .act_mode_o (act_mode),
        .oldest_o   (start_addr_o)
    );

    assign state_o = st;

endmodule

// File: rtl/la_capture_ctrl_chk.sv
module la_capture_ctrl_chk #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          trig_i,
    input logic          wr_en_i,
    input logic [AW-1:0] wr_addr_i,
    input logic [2:0]    state_i,
    input logic [1:0]    mode_i
);

    logic rest;
    logic busy;
    assign rest = (state_i == 3'd0) || (state_i == 3'd4);
    assign busy = (state_i == 3'd1) || (state_i == 3'd2) || (state_i == 3'd3);

    p_no_write_at_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rest |-> !wr_en_i);

    p_addr_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr_i < AW'(DEPTH - 1) || wr_addr_i == AW'(DEPTH - 1));

    p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> wr_addr_i == (($past(wr_addr_i) == AW'(DEPTH - 1)) ? '0 : $past(wr_addr_i) + 1'b1));

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_en_i) |=> $stable(wr_addr_i));

    p_fill_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == 3'd1) |-> wr_en_i);

    p_fill_ignores_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == 3'd1) |=> (state_i == 3'd1 || state_i == 3'd2));

    p_incr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == 3'd3 && mode_i == 2'd1) |-> (wr_en_i == trig_i));

    p_stream_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == 3'd3 && mode_i != 2'd1) |-> wr_en_i);

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rest && start_i) |=> busy);

    p_done_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == 3'd4 && !start_i) |=> state_i == 3'd4);

endmodule

bind la_capture_ctrl la_capture_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .trig_i    (trig_i),
    .wr_en_i   (wr_en_o),
    .wr_addr_i (wr_addr_o),
    .state_i   (state_o),
    .mode_i    (act_mode)
);

// File: tb/la_capture_ctrl_bench.sv
`timescale 1ns/1ps
module la_capture_ctrl_bench;

    localparam int DEPTH = 8;
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [PW-1:0] cfg_pos = '0;
    logic          start = 1'b0;
    logic          trig = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [2:0]    state;
    logic [AW-1:0] start_addr;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int mem [DEPTH];

    la_capture_ctrl #(.DEPTH(DEPTH)) u_la_capture_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_mode_i   (cfg_mode),
        .cfg_pos_i    (cfg_pos),
        .start_i      (start),
        .trig_i       (trig),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .state_o      (state),
        .start_addr_o (start_addr)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // memory model: sample tag = cycle index, recorded just before the edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (wr_en) mem[wr_addr] = cyc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cfg(input int m, input int p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 2'(m); cfg_pos = PW'(p);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic go(output int s);
        @(negedge clk);
        start = 1'b1; s = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse(output int t);
        @(negedge clk);
        trig = 1'b1; t = cyc;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k = 0;
        while (state != 3'd4 && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk(req, int'(state), 4);
    endtask

    task automatic check_run(input string req, input int first);
        for (int i = 0; i < DEPTH; i++)
            chk(req, mem[(int'(start_addr) + i) % DEPTH], first + i);
    endtask

    // R1 reset values and defaults
    task automatic t_reset;
        chk("R1 state", int'(state), 0);
        chk("R1 wr_en", int'(wr_en), 0);
        chk("R1 wr_addr", int'(wr_addr), 0);
        chk("R1 start_addr", int'(start_addr), 0);
    endtask

    // R1/R6/R9 default single-shot, trigger in the middle
    task automatic t_default;
        int s, t;
        go(s);
        tick(12);
        chk("R4 armed writing", int'(wr_en), 1);
        pulse(t);
        wait_done("R6 done");
        chk("R9 start_addr", int'(start_addr), (((t - s - 5) % DEPTH) + DEPTH) % DEPTH);
        check_run("R6 R1 window", t - 4);
    endtask

    // R3 early trigger ignored; R2 restart from DONE
    task automatic t_early;
        int s, t;
        go(s);
        chk("R2 restart state", int'(state), 1);
        @(negedge clk); trig = 1'b1;
        tick(2);
        trig = 1'b0;
        chk("R3 early trig ignored", int'(state), 1);
        tick(8);
        pulse(t);
        wait_done("R3 done");
        check_run("R3 window", t - 4);
    endtask

    // R5 position zero: trigger first, no pre-trigger writes
    task automatic t_pos0;
        int s, t;
        set_cfg(0, 0);
        go(s);
        tick(3);
        chk("R4 armed idle write", int'(wr_en), 0);
        chk("R4 armed state", int'(state), 2);
        pulse(t);
        wait_done("R5 done");
        chk("R5 start_addr", int'(start_addr), 0);
        check_run("R5 first", t);
    endtask

    // R5 position at depth: trigger last
    task automatic t_posmax;
        int s, t;
        set_cfg(0, DEPTH);
        go(s);
        tick(12);
        pulse(t);
        chk("R5 done at trigger", int'(state), 4);
        check_run("R5 last", t - (DEPTH - 1));
    endtask

    // R7 incremental keeps only trigger cycles after the first
    task automatic t_incr;
        int s, t;
        int exp_tag [DEPTH];
        set_cfg(1, 2);
        go(s);
        tick(4);
        pulse(t);
        exp_tag[0] = t - 2; exp_tag[1] = t - 1; exp_tag[2] = t;
        for (int i = 3; i < DEPTH; i++) begin
            tick(2);
            pulse(t);
            exp_tag[i] = t;
            if (i == DEPTH - 2) chk("R7 waits for trigger", int'(state), 3);
        end
        tick(3);
        chk("R7 done", int'(state), 4);
        for (int i = 0; i < DEPTH; i++)
            chk("R7 kept", mem[(int'(start_addr) + i) % DEPTH], exp_tag[i]);
    endtask

    // R8 immediate ignores trigger
    task automatic t_immed;
        int s;
        set_cfg(2, 4);
        trig = 1'b0;
        go(s);
        chk("R8 capturing", int'(state), 3);
        wait_done("R8 done");
        chk("R8 start_addr", int'(start_addr), 0);
        check_run("R8 window", s + 1);
    endtask

    // R2 config written and start pulsed mid-capture have no effect
    task automatic t_snapshot;
        int s, s2, t;
        set_cfg(0, 4);
        go(s);
        tick(8);
        set_cfg(2, 0);
        go(s2);
        tick(3);
        chk("R2 still armed", int'(state), 2);
        pulse(t);
        wait_done("R2 done");
        check_run("R2 window", t - 4);
    endtask

    // R11 mode code 3 acts as single-shot
    task automatic t_alt;
        int s, t;
        set_cfg(3, 0);
        go(s);
        tick(5);
        chk("R11 waits for trigger", int'(state), 2);
        pulse(t);
        tick(1);
        chk("R11 streaming", int'(wr_en), 1);
        wait_done("R11 done");
        check_run("R11 window", t);
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = -1;
        tick(3);
        t_reset;
        rst_n = 1'b1;
        tick(2);
        t_reset;
        t_default;
        t_early;
        t_pos0;
        t_posmax;
        t_incr;
        t_immed;
        t_snapshot;
        t_alt;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule